// File: doc/BRIEF.md
# Bounded FIFO Read Controller with Commit

This block is the reader half of a FIFO whose storage is an external dual-port memory with one cycle of read latency. The storage region is given by a low and a high address bound, and its size need not be a power of two. The read pointer walks from the low bound to the high bound and then wraps back to the low bound. The write controller publishes a committed write pointer. The reader treats everything before that pointer as readable, so writes that are not yet committed stay invisible. The reader returns its own committed read pointer to the writer, which uses it for the full check. Emptiness is equality of the current read pointer and the committed write pointer, so the writer must keep one slot free.

Fetched words land in a two-entry output buffer. That buffer is presented to the consumer with a valid/ready handshake. A fetch is issued whenever the buffer plus the read in flight leave room after this cycle's pop, which allows one pop per cycle. An arbitration enable can hold off memory reads and read-pointer moves at any time.

When built with the commit option, popped entries stay reserved until the consumer commits them. A commit pulse hands everything popped so far (including a pop in the same cycle) back to the writer. An abort pulse discards the buffer and any read in flight, and rewinds so that the uncommitted entries are delivered again. Without the option, every pop releases its entry at once and both pulses are ignored.

Top module: `fifoReadCtl`

## Requirements
- R1: While `rstN` is low and in the cycle after its release, `outValid` and `memRdEn` are 0, and `comRdPtr` equals `boundLow`. After release, `usage` is 0 as long as `comWrPtr` equals `boundLow`.
- R2: Every read has `memRdAddr` inside [`boundLow`, `boundHigh`]. After a read at `boundHigh`, the next read address is `boundLow`.
- R3: While `enable` is 0, `memRdEn` is 0 and the read address does not advance.
- R4: No read is issued while the current read pointer equals `comWrPtr`. Memory contents beyond `comWrPtr` are never delivered.
- R5: Entries are delivered in address order. With `outReady` held high and entries available, `outValid` is 1 in every cycle (one pop per cycle).
- R6: While `outValid` is 1 and `outReady` is 0, the next cycle keeps `outValid` at 1 and `outData` unchanged.
- R7: `usage` equals `comWrPtr - comRdPtr`. When that difference is negative, `boundHigh - boundLow + 1` is added to it.
- R8: With COMMIT_EN = 0, `comRdPtr` advances by one wrapped step on every pop, and `popCommit` and `popAbort` have no effect.
- R9: With COMMIT_EN = 1, `comRdPtr` changes only on a `popCommit` cycle. It then becomes the position after the last popped entry, counting a pop in that same cycle.
- R10: With COMMIT_EN = 1, the cycle after `popAbort` has `outValid` = 0. Delivery then restarts at the committed position, and any read in flight is discarded.
- R11: Data is taken from `memRdData` in the cycle after the `memRdEn` cycle. From an empty buffer, `outValid` rises two cycles after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Arbitration grant for reads and read-pointer moves |
| boundLow | input | ADDR_W | First address of the region |
| boundHigh | input | ADDR_W | Last address of the region |
| comWrPtr | input | ADDR_W | Committed write pointer from the write controller |
| memRdEn | output | 1 | Memory read enable |
| memRdAddr | output | ADDR_W | Memory read address |
| memRdData | input | DATA_W | Memory read data, one cycle after the read |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts the output word |
| outData | output | DATA_W | Output word |
| popCommit | input | 1 | Release all popped entries to the writer |
| popAbort | input | 1 | Rewind to the committed position |
| comRdPtr | output | ADDR_W | Committed read pointer to the write controller |
| usage | output | ADDR_W+1 | Entries held between committed pointers |

## Verification
A commit can fall in the same cycle as a pop. The bench provokes this by holding one entry in the buffer, then raising `outReady` and `popCommit` together for a single cycle. It judges the result by requiring that `comRdPtr` lands one step past that entry, not on it. An abort can also fall while a fetch is in flight. The bench aborts during a steady stream of pops and expects `outValid` low in the next cycle. The scoreboard then requires that the three uncommitted entries come back in order, with no stray word from the discarded read.

// File: rtl/fifoRdPkg.sv
package fifoRdPkg;
  // strobes from pointer control to the output buffer
  typedef struct packed {
    logic fetch;  // memory read issued this cycle
    logic land;   // read data present on memRdData this cycle, to be kept
    logic pop;    // consumer takes the head word
    logic flush;  // discard all buffered words
  } rdStrobe_t;
endpackage

// File: rtl/rdUsageCalc.sv
module rdUsageCalc #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] boundLow,
  input  logic [ADDR_W-1:0] boundHigh,
  input  logic [ADDR_W-1:0] comWrPtr,
  input  logic [ADDR_W-1:0] comRdPtr,
  output logic [ADDR_W:0]   usage
);
  logic [ADDR_W:0] span;
  logic [ADDR_W:0] rawDiff;

  always_comb begin
    span    = {1'b0, boundHigh} - {1'b0, boundLow} + 1'b1;
    rawDiff = {1'b0, comWrPtr} - {1'b0, comRdPtr};
    if (comWrPtr >= comRdPtr) usage = rawDiff;
    else                      usage = rawDiff + span;
  end
endmodule

// File: rtl/rdPtrCtl.sv
module rdPtrCtl
  import fifoRdPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter bit COMMIT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [ADDR_W-1:0] boundLow,
  input  logic [ADDR_W-1:0] boundHigh,
  input  logic [ADDR_W-1:0] comWrPtr,
  input  logic              outReady,
  input  logic              popCommit,
  input  logic              popAbort,
  input  logic [1:0]        heldCnt,
  output rdStrobe_t         strobe,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] comRdPtr
);
  logic [ADDR_W-1:0] curRdPtr;
  logic [ADDR_W-1:0] popPtr;
  logic [ADDR_W-1:0] popPtrNext;
  logic [ADDR_W-1:0] comNext;
  logic              pending;
  logic              doPop;
  logic              abortEff;
  logic              commitEff;
  logic              hasData;
  logic              hasRoom;
  logic              doFetch;
  logic [2:0]        inFlight;

  function automatic logic [ADDR_W-1:0] stepPtr(
    input logic [ADDR_W-1:0] p,
    input logic [ADDR_W-1:0] lo,
    input logic [ADDR_W-1:0] hi
  );
    return (p == hi) ? lo : p + 1'b1;
  endfunction

  generate
    if (COMMIT_EN) begin : g_commit
      assign abortEff  = popAbort;
      assign commitEff = popCommit;
      assign comNext   = commitEff ? popPtrNext : comRdPtr;
    end else begin : g_direct
      assign abortEff  = 1'b0;
      assign commitEff = 1'b0;
      assign comNext   = popPtrNext;
    end
  endgenerate

  always_comb begin
    doPop      = (heldCnt != 2'd0) && outReady;
    hasData    = (curRdPtr != comWrPtr);
    inFlight   = {1'b0, heldCnt} + {2'b00, pending};
    hasRoom    = inFlight <= (3'd1 + {2'b00, doPop});
    doFetch    = rstN && enable && hasData && hasRoom && !abortEff;
    popPtrNext = doPop ? stepPtr(popPtr, boundLow, boundHigh) : popPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRdPtr <= boundLow;
      popPtr   <= boundLow;
      comRdPtr <= boundLow;
      pending  <= 1'b0;
    end else begin
      pending  <= doFetch;
      comRdPtr <= comNext;
      if (abortEff) begin
        curRdPtr <= comNext;
        popPtr   <= comNext;
      end else begin
        popPtr <= popPtrNext;
        if (doFetch) curRdPtr <= stepPtr(curRdPtr, boundLow, boundHigh);
      end
    end
  end

  assign memRdEn      = doFetch;
  assign memRdAddr    = curRdPtr;
  assign strobe.fetch = doFetch;
  assign strobe.land  = pending && !abortEff;
  assign strobe.pop   = doPop;
  assign strobe.flush = abortEff;

  // R2: reads stay inside the region
  p_addr_in_region_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memRdAddr >= boundLow) && (memRdAddr <= boundHigh));
  // R2: the read after the high bound goes to the low bound
  p_wrap_to_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && memRdAddr == boundHigh && !popAbort) |=> (memRdAddr == boundLow));
  // R3: no read without the grant
  p_no_read_ungranted_r3: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !memRdEn);
  // R4: never read the slot the writer points to
  p_no_read_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memRdAddr != comWrPtr));
  // R10: an abort empties the output buffer
  p_abort_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    abortEff |=> (heldCnt == 2'd0));

  generate
    if (COMMIT_EN) begin : g_commit_chk
      // R9: committed pointer moves only on commit
      p_commit_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
        !popCommit |=> $stable(comRdPtr));
    end
  endgenerate
endmodule

// File: rtl/rdOutBuf.sv
module rdOutBuf
  import fifoRdPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [DATA_W-1:0] memRdData,
  output logic [1:0]        heldCnt,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] headWord;
  logic [DATA_W-1:0] tailWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldCnt  <= 2'd0;
      headWord <= '0;
      tailWord <= '0;
    end else if (strobe.flush) begin
      heldCnt <= 2'd0;
    end else begin
      unique case ({strobe.land, strobe.pop})
        2'b01: begin
          headWord <= tailWord;
          heldCnt  <= heldCnt - 2'd1;
        end
        2'b10: begin
          if (heldCnt == 2'd0) headWord <= memRdData;
          else                 tailWord <= memRdData;
          heldCnt <= heldCnt + 2'd1;
        end
        2'b11: begin
          if (heldCnt == 2'd1) headWord <= memRdData;
          else begin
            headWord <= tailWord;
            tailWord <= memRdData;
          end
        end
        default: ;
      endcase
    end
  end

  assign outValid = (heldCnt != 2'd0);
  assign outData  = headWord;

  // R5: a landing word always has a slot
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.land && !strobe.pop && !strobe.flush) |-> (heldCnt != 2'd2));
  // R5: no fetch is launched into a full buffer that is not draining
  p_fetch_room_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fetch && !strobe.pop) |-> (heldCnt != 2'd2));
  // R6: a stalled word stays put
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !strobe.pop && !strobe.flush) |=> (outValid && $stable(outData)));
endmodule

// File: rtl/fifoReadCtl.sv
module fifoReadCtl
  import fifoRdPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter bit COMMIT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [ADDR_W-1:0] boundLow,
  input  logic [ADDR_W-1:0] boundHigh,
  input  logic [ADDR_W-1:0] comWrPtr,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  input  logic              popCommit,
  input  logic              popAbort,
  output logic [ADDR_W-1:0] comRdPtr,
  output logic [ADDR_W:0]   usage
);
  rdStrobe_t  strobe;
  logic [1:0] heldCnt;

  rdPtrCtl #(.ADDR_W(ADDR_W), .COMMIT_EN(COMMIT_EN)) ctl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .boundLow(boundLow), .boundHigh(boundHigh), .comWrPtr(comWrPtr),
    .outReady(outReady), .popCommit(popCommit), .popAbort(popAbort),
    .heldCnt(heldCnt), .strobe(strobe),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .comRdPtr(comRdPtr)
  );

  rdOutBuf #(.DATA_W(DATA_W)) buffer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .heldCnt(heldCnt), .outValid(outValid), .outData(outData)
  );

  rdUsageCalc #(.ADDR_W(ADDR_W)) occ (
    .boundLow(boundLow), .boundHigh(boundHigh),
    .comWrPtr(comWrPtr), .comRdPtr(comRdPtr), .usage(usage)
  );
endmodule

// File: tb/fifoReadCtl_test.sv
module fifoReadCtl_test;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam logic [AW-1:0] LO = 4'd3;
  localparam logic [AW-1:0] HI = 4'd12;
  localparam logic [AW-1:0] NLO = 4'd0;
  localparam logic [AW-1:0] NHI = 4'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  // commit-mode instance
  logic          enable = 1'b1;
  logic [AW-1:0] comWrPtr = LO;
  logic          memRdEn;
  logic [AW-1:0] memRdAddr;
  logic [DW-1:0] memRdData;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [DW-1:0] outData;
  logic          popCommit = 1'b0;
  logic          popAbort = 1'b0;
  logic [AW-1:0] comRdPtr;
  logic [AW:0]   usage;
  logic [DW-1:0] mem [16];

  // direct-release instance
  logic [AW-1:0] ncWrPtr = NLO;
  logic          ncRdEn;
  logic [AW-1:0] ncRdAddr;
  logic [DW-1:0] ncRdData;
  logic          ncValid;
  logic          ncReady = 1'b0;
  logic [DW-1:0] ncData;
  logic          ncCommit = 1'b0;
  logic          ncAbort = 1'b0;
  logic [AW-1:0] ncComRd;
  logic [AW:0]   ncUsage;
  logic [DW-1:0] ncMem [16];

  fifoReadCtl #(.DATA_W(DW), .ADDR_W(AW), .COMMIT_EN(1'b1)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .boundLow(LO), .boundHigh(HI),
    .comWrPtr(comWrPtr), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .popCommit(popCommit), .popAbort(popAbort),
    .comRdPtr(comRdPtr), .usage(usage));

  fifoReadCtl #(.DATA_W(DW), .ADDR_W(AW), .COMMIT_EN(1'b0)) uutNc (
    .clk(clk), .rstN(rstN), .enable(1'b1), .boundLow(NLO), .boundHigh(NHI),
    .comWrPtr(ncWrPtr), .memRdEn(ncRdEn), .memRdAddr(ncRdAddr),
    .memRdData(ncRdData), .outValid(ncValid), .outReady(ncReady),
    .outData(ncData), .popCommit(ncCommit), .popAbort(ncAbort),
    .comRdPtr(ncComRd), .usage(ncUsage));

  // memory models with one cycle of read latency
  always_ff @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memRdAddr];
    if (ncRdEn)  ncRdData  <= ncMem[ncRdAddr];
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == HI) ? LO : p + 1'b1;
  endfunction

  // scoreboard state
  logic [DW-1:0] expQ[$];
  logic [DW-1:0] uncom[$];
  logic [AW-1:0] wpStage = LO;
  logic [AW-1:0] popAddr = LO;
  logic [AW-1:0] comAddrExp = LO;
  logic [DW-1:0] dataSeq = 8'h10;
  int            popCnt = 0;
  bit            sawWrap = 1'b0;
  logic [AW-1:0] lastRd = LO;
  bit            lastRdValid = 1'b0;
  int            ncIdx = 0;

  // driver: stage a word behind the committed write pointer
  task automatic stageItem();
    while (nxt(wpStage) == comRdPtr) @(negedge clk);
    mem[wpStage] = dataSeq;
    expQ.push_back(dataSeq);
    dataSeq = dataSeq + 8'd1;
    wpStage = nxt(wpStage);
  endtask

  task automatic publish();
    @(posedge clk); #1;
    comWrPtr = wpStage;
  endtask

  task automatic commitPulse();
    @(posedge clk); #1; popCommit = 1'b1;
    @(posedge clk); #1; popCommit = 1'b0;
  endtask

  task automatic drain();
    @(posedge clk); #1; outReady = 1'b1;
    while (expQ.size() != 0) begin @(negedge clk); #2; end
    @(posedge clk); #1; outReady = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R5 unexpected word", int'(outData), -1);
        else begin
          check(outData == expQ[0], "R5 data order", int'(outData), int'(expQ[0]));
          void'(expQ.pop_front());
        end
        uncom.push_back(outData);
        popAddr = nxt(popAddr);
        popCnt++;
      end
      if (popCommit) begin
        uncom.delete();
        comAddrExp = popAddr;
      end
      if (popAbort) begin
        for (int i = uncom.size() - 1; i >= 0; i--) expQ.push_front(uncom[i]);
        uncom.delete();
        popAddr = comAddrExp;
      end
      if (memRdEn) begin
        if (memRdAddr < LO || memRdAddr > HI)
          check(1'b0, "R2 address in region", int'(memRdAddr), int'(LO));
        if (lastRdValid && lastRd == HI && memRdAddr == LO) sawWrap = 1'b1;
        lastRd = memRdAddr;
        lastRdValid = 1'b1;
      end
      if (ncValid && ncReady) begin
        check(ncData == 8'hA0 + DW'(ncIdx), "R8 direct order", int'(ncData), 160 + ncIdx);
        ncIdx++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    int cnt;
    for (int i = 0; i < 16; i++) begin mem[i] = 8'hEE; ncMem[i] = 8'hEE; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid in reset", int'(outValid), 0);
    check(memRdEn == 1'b0, "R1 no read in reset", int'(memRdEn), 0);
    check(comRdPtr == LO, "R1 committed ptr in reset", int'(comRdPtr), int'(LO));
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    check(usage == 0, "R1 usage after reset", int'(usage), 0);
    check(outValid == 1'b0, "R1 valid after reset", int'(outValid), 0);

    // R4: staged but unpublished words are invisible
    stageItem(); stageItem();
    cnt = 0;
    repeat (4) begin @(negedge clk); if (memRdEn || outValid) cnt++; end
    check(cnt == 0, "R4 unpublished invisible", cnt, 0);
    publish();
    drain();
    commitPulse();
    @(negedge clk);
    check(comRdPtr == popAddr, "R9 commit position", int'(comRdPtr), int'(popAddr));

    // R11: read latency from an empty buffer
    stageItem();
    publish();
    @(negedge clk);
    check(memRdEn == 1'b1, "R11 read issued", int'(memRdEn), 1);
    @(negedge clk);
    check(outValid == 1'b0, "R11 valid not yet", int'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1, "R11 valid after two cycles", int'(outValid), 1);
    check(outData == expQ[0], "R11 landed data", int'(outData), int'(expQ[0]));
    drain();
    commitPulse();

    // R6 / R7: stall with a full buffer
    repeat (7) stageItem();
    publish();
    repeat (4) @(negedge clk);
    check(usage == 7, "R7 usage seven", int'(usage), 7);
    check(memRdEn == 1'b0, "R5 no fetch into full buffer", int'(memRdEn), 0);
    base = int'(outData);
    cnt = 0;
    repeat (3) begin @(negedge clk); if (!outValid || int'(outData) != base) cnt++; end
    check(cnt == 0, "R6 stall hold", cnt, 0);

    // R5: full rate, crossing the wrap
    stageItem(); stageItem();
    publish();
    repeat (3) @(negedge clk);
    @(posedge clk); #1; outReady = 1'b1;
    cnt = 0;
    repeat (9) begin @(negedge clk); if (outValid) cnt++; end
    check(cnt == 9, "R5 one pop per cycle", cnt, 9);
    check(usage == 9, "R9 uncommitted still held", int'(usage), 9);
    check(sawWrap == 1'b1, "R2 wrap high to low", int'(sawWrap), 1);
    @(posedge clk); #1; outReady = 1'b0;
    commitPulse();
    @(negedge clk);
    check(usage == 0, "R7 usage after commit", int'(usage), 0);
    check(comRdPtr == popAddr, "R9 commit after wrap", int'(comRdPtr), int'(popAddr));

    // R10: abort mid-stream
    repeat (5) stageItem();
    publish();
    base = popCnt;
    @(posedge clk); #1; outReady = 1'b1;
    while (popCnt < base + 3) begin @(negedge clk); #2; end
    @(posedge clk); #1; outReady = 1'b0; popAbort = 1'b1;
    @(posedge clk); #1; popAbort = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R10 valid dropped", int'(outValid), 0);
    check(expQ.size() == 5, "R10 rewound count", expQ.size(), 5);
    drain();
    commitPulse();

    // R9: commit in the same cycle as a pop
    stageItem();
    publish();
    repeat (3) @(negedge clk);
    @(posedge clk); #1; outReady = 1'b1; popCommit = 1'b1;
    @(posedge clk); #1; outReady = 1'b0; popCommit = 1'b0;
    @(negedge clk);
    check(comRdPtr == wpStage, "R9 commit with pop", int'(comRdPtr), int'(wpStage));
    check(usage == 0, "R7 empty after commit with pop", int'(usage), 0);

    // R3: no reads without the grant
    @(posedge clk); #1; enable = 1'b0;
    repeat (3) stageItem();
    publish();
    cnt = 0;
    repeat (5) begin @(negedge clk); if (memRdEn || outValid) cnt++; end
    check(cnt == 0, "R3 gated reads", cnt, 0);
    check(usage == 3, "R7 usage while gated", int'(usage), 3);
    @(posedge clk); #1; enable = 1'b1;
    drain();
    commitPulse();

    // R8: direct release, commit and abort ignored
    for (int i = 0; i < 4; i++) ncMem[i] = 8'hA0 + DW'(i);
    @(posedge clk); #1;
    ncWrPtr = 4'd4; ncReady = 1'b1; ncCommit = 1'b1; ncAbort = 1'b1;
    repeat (10) @(negedge clk);
    check(ncIdx == 4, "R8 all words once", ncIdx, 4);
    check(ncComRd == 4'd4, "R8 released on pop", int'(ncComRd), 4);
    check(ncUsage == 0, "R8 usage zero", int'(ncUsage), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule